// File: doc/BRIEF.md
# Indexed Byte Configuration Port

This block exposes 256 byte-wide configuration registers through only two bus addresses. Software first writes a register number to the lower address (the selector). It then reads or writes the chosen register through the upper address (the window). Each register number has its own write policy. Some numbers never change. Two numbers take only one specific byte value. The remaining numbers take any byte. A rejected write is dropped without any indication.

The port responds only while a chosen bit of an external enable byte is high. While that bit is low, reads return 0xFF and every write is lost, including writes to the selector. Reset loads fixed defaults into some registers. Storage is built only for the registers that can hold a value other than zero.

Top module: `cfgp_port`

## Requirements
- R1: A write to BASE_ADDR while the port is on loads the 8-bit write data into the selector. Later window reads use the new selector value.
- R2: A read at BASE_ADDR+1 while the port is on returns the register chosen by the selector. The result appears combinationally in the same cycle as the read strobe. Reads never change any state.
- R3: Window writes are dropped when the selector is any of: 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB, 0xFD–0xFF. These registers always read 0x00.
- R4: Register 0xE7 stores a window write only when the data is 0xFE. Any other data leaves it unchanged.
- R5: Register 0xE8 stores a window write only when the data is 0xBE. Any other data leaves it unchanged.
- R6: Registers 0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC store any byte written through the window.
- R7: After reset, the registers read as follows:
  - 0xE0 = 0x3C
  - 0xE2 = 0x03
  - 0xE3 = 0xFC
  - 0xE6 = 0xDE
  - 0xE7 = 0xFE
  - 0xE8 = 0xBE
  - every other register = 0x00
  - the selector = 0x00
- R8: While bit EN_BIT (default 1) of the enable byte is 0, read data is 0xFF and writes to either address leave the selector and all registers unchanged. The port is off during reset.
- R9: Accesses to addresses other than BASE_ADDR and BASE_ADDR+1 change nothing, and reads at them return 0xFF. This includes reads at BASE_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 8 | External enable byte; bit EN_BIT switches the port on |
| bus_addr | input | ADDR_W | Byte bus address |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0xFF when nothing is decoded |

## Verification
The assertions assume that read and write strobes are never high in the same cycle. They also assume that the enable byte and the address are held steady for the whole cycle in which a strobe is high. The bench drives one access per cycle, changes inputs only on the falling edge, and keeps the two strobes mutually exclusive. Under those rules, each window property can compare the register contents with the value it had one cycle earlier.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned IDX_W   = 8;
  localparam int unsigned BANK_N  = 32;
  localparam logic [7:0]  BANK_LO = 8'hE0;

  // Indices whose window writes are always dropped.
  function automatic logic idx_read_only(input logic [7:0] i);
    if (i < BANK_LO) return 1'b1;
    case (i)
      8'hE4, 8'hE5, 8'hE9, 8'hEA, 8'hEB, 8'hEC, 8'hED,
      8'hF3, 8'hF5, 8'hF7, 8'hF9, 8'hFA, 8'hFB,
      8'hFD, 8'hFE, 8'hFF: return 1'b1;
      default:             return 1'b0;
    endcase
  endfunction

  // Full write policy: range filter plus the two value-locked registers.
  function automatic logic write_ok(input logic [7:0] i, input logic [7:0] d);
    if (idx_read_only(i)) return 1'b0;
    if (i == 8'hE7)       return d == 8'hFE;
    if (i == 8'hE8)       return d == 8'hBE;
    return 1'b1;
  endfunction

  function automatic logic [7:0] reset_val(input logic [7:0] i);
    case (i)
      8'hE0:   return 8'h3C;
      8'hE2:   return 8'h03;
      8'hE3:   return 8'hFC;
      8'hE6:   return 8'hDE;
      8'hE7:   return 8'hFE;
      8'hE8:   return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
  parameter int unsigned EN_BIT    = 1
) (
  input  logic [7:0]        cfg_enable,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic              port_on,
  output logic              sel_wr,
  output logic              win_wr,
  output logic              win_rd
);
  localparam logic [ADDR_W-1:0] WIN_ADDR = BASE_ADDR + 1'b1;

  logic at_sel, at_win;
  logic unused_en;

  assign unused_en = ^cfg_enable;
  assign port_on   = cfg_enable[EN_BIT];
  assign at_sel    = (bus_addr == BASE_ADDR);
  assign at_win    = (bus_addr == WIN_ADDR);
  assign sel_wr    = port_on & bus_wr & at_sel;
  assign win_wr    = port_on & bus_wr & at_win;
  assign win_rd    = port_on & bus_rd & at_win;
endmodule

// File: rtl/cfgp_index.sv
module cfgp_index
  import cfgp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr,
  input  logic [DW-1:0]    wdata,
  output logic [IDX_W-1:0] idx_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      idx_q <= '0;
    else if (sel_wr) idx_q <= wdata;
  end
endmodule

// File: rtl/cfgp_bank.sv
module cfgp_bank
  import cfgp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_wr,
  input  logic [IDX_W-1:0] idx_q,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    sel_q,
  output logic             wr_accept
);
  localparam int unsigned SLOT_W = $clog2(BANK_N);

  logic [DW-1:0] slot [BANK_N];

  assign wr_accept = win_wr & write_ok(idx_q, wdata);

  for (genvar s = 0; s < BANK_N; s++) begin : g_slot
    localparam logic [7:0] SLOT_IDX = 8'(int'(BANK_LO) + s);
    if (idx_read_only(SLOT_IDX)) begin : g_const
      assign slot[s] = '0;
    end else begin : g_store
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          q <= reset_val(SLOT_IDX);
        else if (wr_accept && idx_q == SLOT_IDX)
          q <= wdata;
      end
      assign slot[s] = q;
    end
  end

  assign sel_q = (idx_q >= BANK_LO) ? slot[idx_q[SLOT_W-1:0]] : '0;
endmodule

// File: rtl/cfgp_port.sv
module cfgp_port #(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
  parameter int unsigned EN_BIT    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cfg_enable,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);
  logic       port_on, sel_wr, win_wr, win_rd, wr_accept;
  logic [7:0] idx_q, sel_q;

  cfgp_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .EN_BIT(EN_BIT)) u_dec (
    .cfg_enable(cfg_enable), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .port_on(port_on), .sel_wr(sel_wr), .win_wr(win_wr), .win_rd(win_rd)
  );

  cfgp_index u_idx (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .wdata(bus_wdata), .idx_q(idx_q)
  );

  cfgp_bank u_bank (
    .clk(clk), .rst_n(rst_n), .win_wr(win_wr), .idx_q(idx_q), .wdata(bus_wdata),
    .sel_q(sel_q), .wr_accept(wr_accept)
  );

  assign bus_rdata = win_rd ? sel_q : 8'hFF;
endmodule

// File: rtl/cfgp_port_chk.sv
module cfgp_port_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
  parameter int unsigned EN_BIT    = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        cfg_enable,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [7:0]        idx_q,
  input logic [7:0]        sel_q,
  input logic              wr_accept
);
  logic on, a_sel, a_win, a_other, open_idx;
  assign on       = cfg_enable[EN_BIT];
  assign a_sel    = bus_addr == BASE_ADDR;
  assign a_win    = bus_addr == BASE_ADDR + 1'b1;
  assign a_other  = !a_sel && !a_win;
  assign open_idx = idx_q inside {8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE6, 8'hEE,
                                  8'hEF, 8'hF0, 8'hF1, 8'hF2, 8'hF4, 8'hF6,
                                  8'hF8, 8'hFC};

  p_index_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    on && bus_wr && a_sel |=> idx_q == $past(bus_wdata));
  p_read_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    on && bus_rd && a_win |-> bus_rdata == sel_q);
  p_ro_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    on && bus_rd && a_win && idx_q < 8'hE0 |-> bus_rdata == 8'h00);
  p_ro_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < 8'hE0 |-> !wr_accept);
  p_lock_e7_r4: assert property (@(posedge clk) disable iff (!rst_n)
    on && bus_wr && a_win && idx_q == 8'hE7 && bus_wdata != 8'hFE |=> $stable(sel_q));
  p_lock_e8_r5: assert property (@(posedge clk) disable iff (!rst_n)
    on && bus_wr && a_win && idx_q == 8'hE8 && bus_wdata != 8'hBE |=> $stable(sel_q));
  p_open_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    on && bus_wr && a_win && open_idx |=> sel_q == $past(bus_wdata));
  p_off_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !on && bus_rd |-> bus_rdata == 8'hFF);
  p_off_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !on && bus_wr |=> $stable(idx_q) && $stable(sel_q));
  p_stray_r9: assert property (@(posedge clk) disable iff (!rst_n)
    a_other && bus_wr |=> $stable(idx_q) && $stable(sel_q));
endmodule

bind cfgp_port cfgp_port_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .EN_BIT(EN_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .idx_q(idx_q), .sel_q(sel_q), .wr_accept(wr_accept)
);

// File: tb/cfgp_port_tb.sv
module cfgp_port_tb;
  localparam logic [15:0] BASE = 16'h03F0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_enable = 8'h00;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;

  int checks = 0, errors = 0;
  int m_mem [256];
  int m_idx = 0;

  always #5 clk = ~clk;

  cfgp_port u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic bit m_accepts(int i, int d);
    if (i inside {'hE0, 'hE1, 'hE2, 'hE3, 'hE6, 'hEE, 'hEF, 'hF0, 'hF1,
                  'hF2, 'hF4, 'hF6, 'hF8, 'hFC}) return 1;
    if (i == 'hE7) return d == 'hFE;
    if (i == 'hE8) return d == 'hBE;
    return 0;
  endfunction

  function automatic string req_for(int i);
    if (i == 'hE7) return "R4";
    if (i == 'hE8) return "R5";
    if (m_accepts(i, 0)) return "R6";
    return "R3";
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  // One bus cycle; the reference model is compared and then advanced at the edge.
  task automatic bus_op(logic [15:0] a, bit wr, bit rd, logic [7:0] wd, string req);
    int exp;
    @(negedge clk);
    bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = wd;
    #1;
    if (rd) begin
      if (cfg_enable[1] && a == BASE + 16'd1) exp = m_mem[m_idx];
      else exp = 'hFF;
      check(req, bus_rdata, 8'(exp));
    end
    @(posedge clk);
    if (cfg_enable[1] && wr && rst_n) begin
      if (a == BASE) m_idx = int'(wd);
      else if (a == BASE + 16'd1 && m_accepts(m_idx, int'(wd))) m_mem[m_idx] = int'(wd);
    end
    #1;
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) m_mem[i] = 0;
    m_mem['hE0] = 'h3C; m_mem['hE2] = 'h03; m_mem['hE3] = 'hFC;
    m_mem['hE6] = 'hDE; m_mem['hE7] = 'hFE; m_mem['hE8] = 'hBE;

    // R8: off in reset
    bus_op(BASE + 16'd1, 0, 1, 8'h00, "R8");
    bus_op(BASE + 16'd1, 0, 1, 8'h00, "R8");
    @(negedge clk); rst_n = 1'b1;
    cfg_enable = 8'h02;

    // R7 / R1 / R2: reset contents of every index
    bus_op(BASE + 16'd1, 0, 1, 8'h00, "R7");
    for (int i = 0; i < 256; i++) begin
      bus_op(BASE, 1, 0, 8'(i), "R1");
      bus_op(BASE + 16'd1, 0, 1, 8'h00, "R7");
    end

    // R3 / R6 / R4 / R5: write a pattern through every index
    for (int i = 0; i < 256; i++) begin
      bus_op(BASE, 1, 0, 8'(i), "R1");
      bus_op(BASE + 16'd1, 1, 0, 8'((i * 37 + 11) ^ 8'h5A), req_for(i));
      bus_op(BASE + 16'd1, 0, 1, 8'h00, req_for(i));
    end

    // R4: value lock on 0xE7
    bus_op(BASE, 1, 0, 8'hE7, "R1");
    bus_op(BASE + 16'd1, 1, 0, 8'h00, "R4");
    bus_op(BASE + 16'd1, 0, 1, 8'h00, "R4");
    bus_op(BASE + 16'd1, 1, 0, 8'hFE, "R4");
    bus_op(BASE + 16'd1, 0, 1, 8'h00, "R4");
    // R5: value lock on 0xE8
    bus_op(BASE, 1, 0, 8'hE8, "R1");
    bus_op(BASE + 16'd1, 1, 0, 8'h55, "R5");
    bus_op(BASE + 16'd1, 0, 1, 8'h00, "R5");
    bus_op(BASE + 16'd1, 1, 0, 8'hBE, "R5");
    bus_op(BASE + 16'd1, 0, 1, 8'h00, "R5");

    // R2: selector switching between two open registers
    bus_op(BASE, 1, 0, 8'hF0, "R1");
    bus_op(BASE + 16'd1, 1, 0, 8'hA5, "R6");
    bus_op(BASE, 1, 0, 8'hF1, "R1");
    bus_op(BASE + 16'd1, 1, 0, 8'h3A, "R6");
    bus_op(BASE + 16'd1, 0, 1, 8'h00, "R2");
    bus_op(BASE, 1, 0, 8'hF0, "R1");
    bus_op(BASE + 16'd1, 0, 1, 8'h00, "R2");

    // R8: port off, other enable bits set
    cfg_enable = 8'hFD;
    bus_op(BASE + 16'd1, 0, 1, 8'h00, "R8");
    bus_op(BASE, 1, 0, 8'hF1, "R8");
    bus_op(BASE + 16'd1, 1, 0, 8'h11, "R8");
    cfg_enable = 8'h02;
    bus_op(BASE + 16'd1, 0, 1, 8'h00, "R8");

    // R9: stray addresses
    bus_op(BASE + 16'd2, 1, 0, 8'hF1, "R9");
    bus_op(BASE - 16'd1, 1, 0, 8'h22, "R9");
    bus_op(BASE, 0, 1, 8'h00, "R9");
    bus_op(BASE + 16'd2, 0, 1, 8'h00, "R9");
    bus_op(BASE + 16'd1, 0, 1, 8'h00, "R9");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule